// File: doc/BRIEF.md
# Transaction Dependence Graph Tracker

This block sits beside the per-core transactional caches and keeps the ordering relations among up to `N` in-flight hardware transactions, one slot per transaction. Instead of aborting one side of every memory conflict, the cache logic reports each conflict as an ordered pair plus a kind. The tracker turns the report into a commit-order edge and refuses any edge that would make the schedule non-serializable. Commit requests are held back while a predecessor is still uncommitted. Aborts spread to every transaction that consumed forwarded speculative data.

Everything enters through one command port (`op_*`, accepted when `in_ready` is high) and through a level-sensitive per-slot commit request vector. The control is a five-state machine:

- **IDLE** accepts commands. A valid conflict moves it to **REACH**. A valid abort or overwrite moves it to **CASCADE**. With no command present and some eligible commit request, it moves to **GRANT**.
- **REACH** walks reachability from the later transaction for `N-1` cycles. It then either records the edge and returns to IDLE, or picks a victim and moves to CASCADE.
- **CASCADE** grows the abort set along receiver links until the set stops changing, then moves to **DROP**.
- **DROP** pulses `restart` and returns to IDLE.
- **GRANT** pulses `grant` for one slot and returns to IDLE.

Top module: `dep_tracker`

## Requirements
- R1: After reset no slot is active, `in_ready` is 1, and `grant`, `restart`, `stall` and `order_vec` are all zero.
- R2: A conflict command (`op_code`=1) between distinct active slots `op_a` (earlier) and `op_b` (later) sets bit `op_a*N+op_b` of `order_vec`, meaning `op_a` commits before `op_b`. The kind values are 0 read-write, 1 write-write, 2 write-read, and 3, which is handled like write-write. A conflict naming an inactive slot, or the same slot twice, changes nothing.
- R3: After a valid conflict is accepted, `in_ready` stays low for exactly `N-1` cycles when no cycle is found.
- R4: A conflict whose edge would close a cycle adds no edge and restarts a victim. The victim is whichever of the two slots has fewer direct receivers; on a tie it is `op_b`. The victim's receivers are restarted with it, through every level.
- R5: A write-read conflict records `op_b` as a receiver of `op_a`. An abort command (`op_code`=2) on active slot `op_a` restarts `op_a` and all of its receivers, through every level.
- R6: An overwrite command (`op_code`=3) by active slot `op_a` restarts all of `op_a`'s receivers, through every level, but not `op_a` itself.
- R7: An active slot that requests commit while it has a predecessor shows `stall` high and is never granted until all of its predecessors are gone.
- R8: When several requesting slots have no predecessor, they are granted one at a time, lowest index first. A slot that becomes free of predecessors through an earlier grant joins the order.
- R9: A slot that is granted or restarted is inactive from the next cycle, and all of its edges and receiver links are cleared in that same cycle.
- R10: At most one `grant` bit is high at a time. A command presented while `in_ready` is low has no effect.
- R11: A start command (`op_code`=0) activates a free slot. A start on an already active slot changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Command present |
| op_code | input | 2 | 0 start, 1 conflict, 2 abort, 3 overwrite |
| op_a | input | clog2(N) | Subject slot; earlier slot of a conflict |
| op_b | input | clog2(N) | Later slot of a conflict |
| op_kind | input | 2 | Conflict kind: 0 RW, 1 WW, 2 WR |
| in_ready | output | 1 | High in IDLE; a command is taken only then |
| commit_req | input | N | Per-slot commit request, level |
| grant | output | N | One-cycle commit grant |
| stall | output | N | Requesting slot blocked by a predecessor |
| restart | output | N | One-cycle restart request |
| active | output | N | Slot holds a live transaction |
| order_vec | output | N*N | Edge matrix, bit a*N+b means a before b |

## Verification
The bench targets the two victim-choice cases, the tie and the case where the earlier slot has fewer receivers. A design that always restarts the later slot fails the second case by restarting a slot that has dependents. Multi-level receiver chains under abort and overwrite catch a cascade that stops after one level, and catch an overwrite that wrongly kills the writer. A commit batch in which a slot is unblocked by an earlier grant in the same batch catches arbitration that skips or reorders it. A command pulsed during the busy window catches a design that accepts input outside IDLE. Random command streams are compared against a behavioural graph model.

// File: rtl/dgt_pkg.sv
`timescale 1ns/1ps
package dgt_pkg;
    typedef enum logic [1:0] {
        OP_START    = 2'd0,
        OP_CONFLICT = 2'd1,
        OP_ABORT    = 2'd2,
        OP_OVERWRITE= 2'd3
    } op_e;

    typedef enum logic [1:0] {
        K_RW = 2'd0,
        K_WW = 2'd1,
        K_WR = 2'd2
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REACH,
        ST_CASCADE,
        ST_DROP,
        ST_GRANT
    } state_e;
endpackage

// File: rtl/dgt_expand.sv
`timescale 1ns/1ps
// One step of set growth over a bit matrix: the result holds the input set
// plus every column reached from a row that is in the set.
module dgt_expand #(
    parameter int N = 4
) (
    input  logic [N-1:0]   seed_set,
    input  logic [N*N-1:0] mat,
    output logic [N-1:0]   grown
);
    always_comb begin
        grown = seed_set;
        for (int i = 0; i < N; i++) begin
            if (seed_set[i]) begin
                grown = grown | mat[i*N +: N];
            end
        end
    end
endmodule

// File: rtl/dgt_pick_low.sv
`timescale 1ns/1ps
// Lowest-index selector built as a ripple chain.
module dgt_pick_low #(
    parameter int N = 4
) (
    input  logic [N-1:0] cand,
    output logic [N-1:0] first
);
    logic [N-1:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign first[i] = cand[i] & ~seen[i];
        if (i < N-1) begin : g_fwd
            assign seen[i+1] = seen[i] | cand[i];
        end
    end
endmodule

// File: rtl/dep_tracker.sv
`timescale 1ns/1ps
module dep_tracker
    import dgt_pkg::*;
#(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1,
    localparam int MW = N * N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [1:0]    op_code,
    input  logic [IW-1:0] op_a,
    input  logic [IW-1:0] op_b,
    input  logic [1:0]    op_kind,
    output logic          in_ready,
    input  logic [N-1:0]  commit_req,
    output logic [N-1:0]  grant,
    output logic [N-1:0]  stall,
    output logic [N-1:0]  restart,
    output logic [N-1:0]  active,
    output logic [MW-1:0] order_vec
);
    state_e        state_q, state_d;
    logic [N-1:0]  live_q;
    logic [MW-1:0] adj_q;       // bit r*N+c : r commits before c
    logic [MW-1:0] recv_q;      // bit r*N+c : c consumed data forwarded by r
    logic [IW-1:0] lat_a, lat_b;
    logic [1:0]    lat_kind;
    logic [N-1:0]  set_q;       // reach set in REACH, abort set in CASCADE/DROP
    logic [N-1:0]  tgt_q;
    logic [IW-1:0] cnt_q;

    logic [N-1:0]  reach_next, casc_next, has_pred, elig, first_elig;

    function automatic logic [N-1:0] slot_bit(input logic [IW-1:0] s);
        return N'(1) << s;
    endfunction

    function automatic logic [MW-1:0] strip(input logic [MW-1:0] m,
                                            input logic [N-1:0]  mask);
        logic [MW-1:0] r;
        r = m;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                if (mask[i] || mask[j]) r[i*N+j] = 1'b0;
            end
        end
        return r;
    endfunction

    function automatic int unsigned fanout(input logic [MW-1:0] m,
                                           input logic [IW-1:0] s);
        return $countones(m[int'(s)*N +: N]);
    endfunction

    // ---------------------------------------------------------------
    // Structural helpers
    // ---------------------------------------------------------------
    dgt_expand #(.N(N)) u_reach (.seed_set(set_q), .mat(adj_q),  .grown(reach_next));
    dgt_expand #(.N(N)) u_casc  (.seed_set(set_q), .mat(recv_q), .grown(casc_next));

    for (genvar c = 0; c < N; c++) begin : g_col
        logic [N-1:0] col;
        for (genvar r = 0; r < N; r++) begin : g_row
            assign col[r] = adj_q[r*N + c];
        end
        assign has_pred[c] = |col;
    end

    assign elig = live_q & commit_req & ~has_pred;
    dgt_pick_low #(.N(N)) u_pick (.cand(elig), .first(first_elig));

    // ---------------------------------------------------------------
    // Command decode
    // ---------------------------------------------------------------
    logic a_ok, b_ok, pair_ok, last_step, cycle_hit;
    logic [IW-1:0] victim;

    assign a_ok      = (int'(op_a) < N) && live_q[op_a];
    assign b_ok      = (int'(op_b) < N) && live_q[op_b];
    assign pair_ok   = a_ok && b_ok && (op_a != op_b);
    assign last_step = (cnt_q == IW'(N-2));
    assign cycle_hit = reach_next[lat_a];
    assign victim    = (fanout(recv_q, lat_a) < fanout(recv_q, lat_b)) ? lat_a : lat_b;

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (op_valid) begin
                    unique case (op_code)
                        OP_START:     state_d = ST_IDLE;
                        OP_CONFLICT:  state_d = pair_ok ? ST_REACH : ST_IDLE;
                        OP_ABORT,
                        OP_OVERWRITE: state_d = a_ok ? ST_CASCADE : ST_IDLE;
                        default:      state_d = ST_IDLE;
                    endcase
                end else if (|elig) begin
                    state_d = ST_GRANT;
                end
            end
            ST_REACH:   if (last_step) state_d = cycle_hit ? ST_CASCADE : ST_IDLE;
            ST_CASCADE: if (casc_next == set_q) state_d = ST_DROP;
            ST_DROP:    state_d = ST_IDLE;
            ST_GRANT:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // ---------------------------------------------------------------
    // Graph and working registers
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q   <= '0;
            adj_q    <= '0;
            recv_q   <= '0;
            lat_a    <= '0;
            lat_b    <= '0;
            lat_kind <= '0;
            set_q    <= '0;
            tgt_q    <= '0;
            cnt_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (op_valid) begin
                        unique case (op_code)
                            OP_START: begin
                                if (int'(op_a) < N) live_q[op_a] <= 1'b1;
                            end
                            OP_CONFLICT: begin
                                lat_a    <= op_a;
                                lat_b    <= op_b;
                                lat_kind <= op_kind;
                                set_q    <= slot_bit(op_b);
                                cnt_q    <= '0;
                            end
                            OP_ABORT:     set_q <= slot_bit(op_a);
                            OP_OVERWRITE: set_q <= a_ok ? recv_q[int'(op_a)*N +: N] : '0;
                            default: ;
                        endcase
                    end else begin
                        tgt_q <= first_elig;
                    end
                end
                ST_REACH: begin
                    cnt_q <= cnt_q + 1'b1;
                    set_q <= reach_next;
                    if (last_step) begin
                        if (cycle_hit) begin
                            set_q <= slot_bit(victim);
                        end else begin
                            adj_q[int'(lat_a)*N + int'(lat_b)] <= 1'b1;
                            if (lat_kind == K_WR)
                                recv_q[int'(lat_a)*N + int'(lat_b)] <= 1'b1;
                        end
                    end
                end
                ST_CASCADE: set_q <= casc_next;
                ST_DROP: begin
                    live_q <= live_q & ~set_q;
                    adj_q  <= strip(adj_q, set_q);
                    recv_q <= strip(recv_q, set_q);
                end
                ST_GRANT: begin
                    live_q <= live_q & ~tgt_q;
                    adj_q  <= strip(adj_q, tgt_q);
                    recv_q <= strip(recv_q, tgt_q);
                end
                default: ;
            endcase
        end
    end

    // ---------------------------------------------------------------
    // Outputs
    // ---------------------------------------------------------------
    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        grant     = (state_q == ST_GRANT) ? tgt_q : '0;
        restart   = (state_q == ST_DROP)  ? set_q : '0;
        stall     = live_q & commit_req & has_pred;
        active    = live_q;
        order_vec = adj_q;
    end
endmodule

// File: rtl/dep_tracker_chk.sv
`timescale 1ns/1ps
module dep_tracker_chk #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [1:0]    op_code,
    input logic [IW-1:0] op_a,
    input logic [IW-1:0] op_b,
    input logic          in_ready,
    input logic [N-1:0]  grant,
    input logic [N-1:0]  stall,
    input logic [N-1:0]  restart,
    input logic [N-1:0]  active,
    input logic [N*N-1:0] order_vec
);
    logic conflict_taken;
    assign conflict_taken = op_valid && in_ready && (op_code == 2'd1)
                         && (int'(op_a) < N) && (int'(op_b) < N)
                         && active[op_a] && active[op_b] && (op_a != op_b);

    a_r10_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r3_busy_after_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_taken |=> !in_ready);

    for (genvar i = 0; i < N; i++) begin : g_slot
        logic col_any;
        always_comb begin
            col_any = 1'b0;
            for (int k = 0; k < N; k++) col_any = col_any | order_vec[k*N + i];
        end

        a_r7_grant_no_pred: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |-> !col_any);

        a_r7_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            stall[i] |-> !grant[i]);

        a_r9_grant_frees: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |=> (!active[i] && !col_any));

        a_r9_restart_frees: assert property (@(posedge clk) disable iff (!rst_n)
            restart[i] |=> (!active[i] && (order_vec[i*N +: N] == '0)));

        a_r2_no_self_edge: assert property (@(posedge clk) disable iff (!rst_n)
            !order_vec[i*N + i]);

        a_r2_edge_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
            (|order_vec[i*N +: N]) |-> active[i]);
    end
endmodule

bind dep_tracker dep_tracker_chk #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_a(op_a), .op_b(op_b), .in_ready(in_ready), .grant(grant),
    .stall(stall), .restart(restart), .active(active), .order_vec(order_vec)
);

// File: tb/dep_tracker_tb.sv
`timescale 1ns/1ps
module dep_tracker_tb;
    localparam int N  = 4;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [1:0]    op_code = '0;
    logic [IW-1:0] op_a = '0, op_b = '0;
    logic [1:0]    op_kind = '0;
    logic          in_ready;
    logic [N-1:0]  commit_req = '0;
    logic [N-1:0]  grant, stall, restart, active;
    logic [N*N-1:0] order_vec;

    dep_tracker #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_a(op_a), .op_b(op_b), .op_kind(op_kind), .in_ready(in_ready),
        .commit_req(commit_req), .grant(grant), .stall(stall),
        .restart(restart), .active(active), .order_vec(order_vec)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_chk = 0, n_err = 0;

    // behavioural model
    logic [N-1:0]   m_act = '0;
    logic [N*N-1:0] m_adj = '0, m_recv = '0;

    // monitors
    logic [N-1:0] restart_acc = '0;
    int glog[64];
    int gcnt = 0;
    always @(negedge clk) if (rst_n) begin
        restart_acc = restart_acc | restart;
        for (int i = 0; i < N; i++)
            if (grant[i] && gcnt < 64) begin glog[gcnt] = i; gcnt++; end
    end

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [N-1:0] bit_of(input int s);
        return N'(1) << s;
    endfunction

    function automatic logic [N-1:0] grow(input logic [N-1:0] s0, input logic [N*N-1:0] m);
        logic [N-1:0] s;
        s = s0;
        for (int it = 0; it < N; it++)
            for (int i = 0; i < N; i++)
                if (s[i]) s = s | m[i*N +: N];
        return s;
    endfunction

    function automatic int recv_count(input int s);
        return $countones(m_recv[s*N +: N]);
    endfunction

    function automatic logic has_pred_m(input int c);
        for (int r = 0; r < N; r++) if (m_adj[r*N + c]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic m_drop(input logic [N-1:0] mask);
        m_act = m_act & ~mask;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (mask[i] || mask[j]) begin m_adj[i*N+j] = 1'b0; m_recv[i*N+j] = 1'b0; end
    endtask

    task automatic model_op(input int code, input int a, input int b, input int k,
                            output logic [N-1:0] rs, output int busy);
        rs = '0; busy = -1;
        case (code)
            0: begin busy = 0; m_act[a] = 1'b1; end
            1: begin
                if (m_act[a] && m_act[b] && a != b) begin
                    if (grow(bit_of(b), m_adj)[a]) begin
                        int v;
                        v = (recv_count(a) < recv_count(b)) ? a : b;
                        rs = grow(bit_of(v), m_recv);
                    end else begin
                        busy = N-1;
                        m_adj[a*N+b] = 1'b1;
                        if (k == 2) m_recv[a*N+b] = 1'b1;
                    end
                end else busy = 0;
            end
            2: if (m_act[a]) rs = grow(bit_of(a), m_recv); else busy = 0;
            default: if (m_act[a]) rs = grow(m_recv[a*N +: N], m_recv); else busy = 0;
        endcase
        if (rs != '0) m_drop(rs);
    endtask

    task automatic wait_ready();
        while (!in_ready) @(negedge clk);
    endtask

    task automatic run_op(input int code, input int a, input int b, input int k, input string tag);
        logic [N-1:0] rs;
        int busy_exp, busy;
        wait_ready();
        model_op(code, a, b, k, rs, busy_exp);
        restart_acc = '0;
        op_valid = 1'b1; op_code = 2'(code); op_a = IW'(a); op_b = IW'(b); op_kind = 2'(k);
        @(negedge clk);
        op_valid = 1'b0;
        busy = 0;
        while (!in_ready) begin busy++; @(negedge clk); end
        @(negedge clk);
        chk({tag, " restart set"}, 64'(restart_acc), 64'(rs));
        chk({tag, " active"}, 64'(active), 64'(m_act));
        chk({tag, " order_vec"}, 64'(order_vec), 64'(m_adj));
        if (busy_exp >= 0) chk({tag, " R3 busy cycles"}, 64'(busy), 64'(busy_exp));
    endtask

    task automatic commit_batch(input logic [N-1:0] req, input string tag);
        int exp_seq[N];
        int n_exp = 0;
        logic [N-1:0] exp_stall;
        forever begin
            int pick = -1;
            for (int i = N-1; i >= 0; i--)
                if (m_act[i] && req[i] && !has_pred_m(i)) pick = i;
            if (pick < 0) break;
            exp_seq[n_exp] = pick; n_exp++;
            m_drop(bit_of(pick));
        end
        exp_stall = '0;
        for (int i = 0; i < N; i++)
            if (m_act[i] && req[i] && has_pred_m(i)) exp_stall[i] = 1'b1;
        wait_ready();
        gcnt = 0;
        commit_req = req;
        repeat (4*N + 4) @(negedge clk);
        chk({tag, " stall"}, 64'(stall), 64'(exp_stall));
        commit_req = '0;
        @(negedge clk);
        chk({tag, " grant count"}, 64'(gcnt), 64'(n_exp));
        for (int i = 0; i < n_exp && i < gcnt; i++)
            chk({tag, " grant order"}, 64'(glog[i]), 64'(exp_seq[i]));
        chk({tag, " R9 active after grants"}, 64'(active), 64'(m_act));
        chk({tag, " R9 order_vec after grants"}, 64'(order_vec), 64'(m_adj));
    endtask

    task automatic clear_all();
        for (int s = 0; s < N; s++) if (m_act[s]) run_op(2, s, 0, 0, "cleanup");
    endtask

    task automatic start_all();
        for (int s = 0; s < N; s++) if (!m_act[s]) run_op(0, s, 0, 0, "R11 start");
    endtask

    initial begin
        #(2_000_000);
        n_err++;
        $display("FAIL watchdog R10 run did not finish");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd7715));
        commit_req = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 in_ready", 64'(in_ready), 64'd1);
        chk("R1 active", 64'(active), 64'd0);
        chk("R1 grant", 64'(grant), 64'd0);
        chk("R1 restart", 64'(restart), 64'd0);
        chk("R1 stall", 64'(stall), 64'd0);
        chk("R1 order_vec", 64'(order_vec), 64'd0);
        commit_req = '0;

        // R11: activation, repeated start ignored
        start_all();
        run_op(0, 1, 0, 0, "R11 repeat start");

        // R2/R3: edge recorded, ignored self conflict
        run_op(1, 0, 1, 0, "R2 edge 0->1");
        run_op(1, 2, 2, 0, "R2 self conflict");

        // R10: command offered while busy is ignored
        begin
            logic [N-1:0] rs; int be;
            wait_ready();
            model_op(1, 2, 3, 1, rs, be);
            op_valid = 1'b1; op_code = 2'd1; op_a = 2; op_b = 3; op_kind = 2'd1;
            @(negedge clk);
            op_code = 2'd2; op_a = 3;            // abort offered while busy
            @(negedge clk);
            op_valid = 1'b0;
            wait_ready();
            @(negedge clk);
            chk("R10 abort while busy ignored", 64'(active), 64'(m_act));
            chk("R10 order_vec", 64'(order_vec), 64'(m_adj));
        end

        // R7: blocked commit; R8: ordered grants incl. newly unblocked slots
        commit_batch(4'b0010, "R7 blocked");
        commit_batch(4'b1111, "R8 batch");

        // R5: abort cascades through receivers
        start_all();
        run_op(1, 0, 1, 2, "R5 wr 0->1");
        run_op(1, 1, 2, 2, "R5 wr 1->2");
        run_op(1, 3, 2, 0, "R5 rw 3->2");
        run_op(2, 0, 0, 0, "R5 abort cascade");

        // R6: overwrite kills receivers, not the writer
        start_all();
        run_op(1, 0, 1, 2, "R6 wr 0->1");
        run_op(1, 1, 2, 2, "R6 wr 1->2");
        run_op(3, 0, 0, 0, "R6 overwrite");

        // R4: tie -> later slot; fewer receivers -> earlier slot
        clear_all();
        start_all();
        run_op(1, 0, 1, 0, "R4 rw 0->1");
        run_op(1, 1, 0, 1, "R4 cycle tie");
        start_all();
        run_op(1, 0, 2, 2, "R4 wr 0->2");
        run_op(1, 0, 1, 0, "R4 rw 0->1 again");
        run_op(1, 1, 0, 1, "R4 cycle fewer receivers");

        // random mix
        clear_all();
        for (int it = 0; it < 80; it++) begin
            int r, a, b, k;
            r = $urandom % 10; a = $urandom % N; b = $urandom % N; k = $urandom % 4;
            if (r < 3)       run_op(0, a, b, k, "R11 random start");
            else if (r < 8)  run_op(1, a, b, k, "R2 R4 random conflict");
            else if (r == 8) run_op(2, a, b, k, "R5 random abort");
            else             run_op(3, a, b, k, "R6 random overwrite");
            if (it % 8 == 7) commit_batch(N'($urandom % (1 << N)), "R7 R8 random commit");
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule